// File: doc/BRIEF.md
# Fast Interrupt Source Controller

This block looks after the single fast interrupt line of a processor. An external request input first passes through a synchronizer. It is then qualified according to a programmable trigger type, which can be either level or edge. The result drives an active-low request output to the core, and only while the line is enabled. Software sets the enable through one write-only command register and clears it through another. A read-only mask register shows the current enable state.

Software also stores the address of the handler. A read of the fast vector register returns that address. In the edge modes, the same read acknowledges the request: it clears the latched edge, so the core can branch to the handler and acknowledge the interrupt in one access. The mode register also holds a priority field. That field is kept and read back, but it has no effect, because this path has no arbitration.

The register bus is a plain single-cycle interface with word addresses. Writes take effect at the clock edge. Read data is combinational while the read strobe is high. The clearing side effect of a vector read happens at the clock edge that ends the read.

Top module: `fiq_src_ctrl`

## Requirements
- R1: After reset the request output is high, the enable bit is 0, the handler address is 0, and the mode register (address 0) reads 0, which means high-level trigger and priority 0.
- R2: Trigger code 00 (mode register bits [1:0]) is high-level: while enabled, the request output is low exactly when the synchronized input is high.
- R3: Trigger code 10 is low-level: while enabled, the request output is low exactly when the synchronized input is low.
- R4: Trigger code 01 is rising-edge: a 0-to-1 transition of the synchronized input sets a pending latch. The latch holds after the input returns low.
- R5: Trigger code 11 is falling-edge: a 1-to-0 transition sets the pending latch. A rising transition does not set it.
- R6: A read of the fast vector register (address 2) returns the value written to the handler address register (address 1). In either edge mode, that read clears the pending latch at its clock edge.
- R7: In the level modes, a fast vector read has no clearing effect, and the request keeps following the input.
- R8: Writing 1 to bit 0 of the enable command (address 3) sets the enable. Writing 1 to bit 0 of the disable command (address 4) clears it. Writing 0 to either has no effect. Bit 0 of the mask register (address 5) shows the enable.
- R9: While disabled, the request output stays high. A latched edge is kept, and it drives the request low again once the line is re-enabled.
- R10: The priority field (mode register bits [6:4]) is stored and read back, and it has no effect on the request.
- R11: Both command registers read as zero.
- R12: The input passes through two flops. In a level mode, a change of the input reaches the request output after exactly two rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fiq_in | input | 1 | Asynchronous fast interrupt source |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (3) | Word address of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, zero when no read |
| fiq_req_n | output | 1 | Active-low fast interrupt request to the core |

## Verification
The bench checks that a short pulse in an edge mode is still requesting after the pulse has gone. A design that followed the raw level would drop the request there. It checks that a vector read clears an edge request but leaves a level request standing, which catches a clear that is applied in every mode. It checks that disabling and re-enabling brings back a held edge, which would fail if the latch were cleared on disable. It also checks that zero writes to the command registers leave the mask untouched and that the priority field changes nothing. The two-edge input latency is sampled cycle by cycle, so a synchronizer with one stage or three stages shows up as a failure.

// File: rtl/fiq_pkg.sv
package fiq_pkg;

  // bit 0 selects edge operation, bit 1 selects inverted polarity
  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_LOW  = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  localparam int unsigned REG_MODE = 0;
  localparam int unsigned REG_SVEC = 1;
  localparam int unsigned REG_FVEC = 2;
  localparam int unsigned REG_EN   = 3;
  localparam int unsigned REG_DIS  = 4;
  localparam int unsigned REG_MASK = 5;

  localparam int unsigned PRIO_LSB = 4;

  function automatic logic trig_is_edge(trig_e m);
    return m[0];
  endfunction

  function automatic logic edge_seen(trig_e m, logic cur, logic prv);
    logic rise;
    logic fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    return m[1] ? fall : rise;
  endfunction

  function automatic logic level_on(trig_e m, logic cur);
    return m[1] ? ~cur : cur;
  endfunction

endpackage

// File: rtl/fiq_sync.sv
module fiq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/fiq_detect.sv
module fiq_detect
  import fiq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  trig_e trig,
  input  logic  lvl,
  input  logic  clr,
  output logic  edge_hit,
  output logic  latch_q,
  output logic  pending
);

  logic prev_q;

  assign edge_hit = trig_is_edge(trig) & edge_seen(trig, lvl, prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (!trig_is_edge(trig)) latch_q <= 1'b0;
      else if (edge_hit)       latch_q <= 1'b1;
      else if (clr)            latch_q <= 1'b0;
    end
  end

  assign pending = trig_is_edge(trig) ? latch_q : level_on(trig, lvl);

endmodule

// File: rtl/fiq_regs.sv
module fiq_regs
  import fiq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output trig_e             trig,
  output logic [DATA_W-1:0] vec_q,
  output logic              enabled,
  output logic              vec_rd
);

  localparam int unsigned PRIO_MSB = PRIO_LSB + PRIO_W - 1;

  logic [PRIO_W-1:0] prio_q;

  function automatic logic hit(logic [ADDR_W-1:0] a, int unsigned r);
    return a == ADDR_W'(r);
  endfunction

  assign vec_rd = rd & hit(addr, REG_FVEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig    <= TRIG_HIGH;
      prio_q  <= '0;
      vec_q   <= '0;
      enabled <= 1'b0;
    end else if (wr) begin
      if (hit(addr, REG_MODE)) begin
        trig   <= trig_e'(wdata[1:0]);
        prio_q <= wdata[PRIO_MSB:PRIO_LSB];
      end
      if (hit(addr, REG_SVEC)) vec_q <= wdata;
      if (hit(addr, REG_EN) && wdata[0])  enabled <= 1'b1;
      if (hit(addr, REG_DIS) && wdata[0]) enabled <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      if (hit(addr, REG_MODE)) begin
        rdata[1:0]               = trig;
        rdata[PRIO_MSB:PRIO_LSB] = prio_q;
      end
      if (hit(addr, REG_SVEC) || hit(addr, REG_FVEC)) rdata = vec_q;
      if (hit(addr, REG_MASK)) rdata[0] = enabled;
    end
  end

endmodule

// File: rtl/fiq_src_ctrl.sv
module fiq_src_ctrl
  import fiq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned PRIO_W      = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fiq_in,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              fiq_req_n
);

  trig_e             trig;
  logic [DATA_W-1:0] vec_q;
  logic              enabled;
  logic              vec_rd;
  logic              sync_lvl;
  logic              edge_hit;
  logic              latch_q;
  logic              pending;

  fiq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (fiq_in),
    .q     (sync_lvl)
  );

  fiq_detect u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig     (trig),
    .lvl      (sync_lvl),
    .clr      (vec_rd),
    .edge_hit (edge_hit),
    .latch_q  (latch_q),
    .pending  (pending)
  );

  fiq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .trig    (trig),
    .vec_q   (vec_q),
    .enabled (enabled),
    .vec_rd  (vec_rd)
  );

  assign fiq_req_n = ~(pending & enabled);

endmodule

// File: rtl/fiq_src_ctrl_chk.sv
module fiq_src_ctrl_chk
  import fiq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              fiq_req_n,
  input trig_e             trig,
  input logic              sync_lvl,
  input logic              edge_hit,
  input logic              latch_q,
  input logic              enabled,
  input logic              vec_rd,
  input logic [DATA_W-1:0] vec_q
);

  logic wr_en_cmd, wr_dis_cmd, rd_cmd;
  assign wr_en_cmd  = bus_wr && bus_addr == ADDR_W'(REG_EN);
  assign wr_dis_cmd = bus_wr && bus_addr == ADDR_W'(REG_DIS);
  assign rd_cmd     = bus_rd && (bus_addr == ADDR_W'(REG_EN) || bus_addr == ADDR_W'(REG_DIS));

  assert_high_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    enabled && trig == TRIG_HIGH |-> fiq_req_n == !sync_lvl);

  assert_low_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enabled && trig == TRIG_LOW |-> fiq_req_n == sync_lvl);

  assert_edge_latches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> latch_q);

  assert_vec_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd && !bus_wr && trig[0] && !edge_hit |=> !latch_q);

  assert_vec_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |-> bus_rdata == vec_q);

  assert_enable_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_cmd && bus_wdata[0] |=> enabled);

  assert_disable_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis_cmd && bus_wdata[0] |=> !enabled);

  assert_zero_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_cmd || wr_dis_cmd) && !bus_wdata[0] |=> $stable(enabled));

  assert_masked_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> fiq_req_n);

  assert_held_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    enabled && trig[0] && latch_q |-> !fiq_req_n);

  assert_cmd_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cmd |-> bus_rdata == '0);

endmodule

bind fiq_src_ctrl fiq_src_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .fiq_req_n (fiq_req_n),
  .trig      (trig),
  .sync_lvl  (sync_lvl),
  .edge_hit  (edge_hit),
  .latch_q   (latch_q),
  .enabled   (enabled),
  .vec_rd    (vec_rd),
  .vec_q     (vec_q)
);

// File: tb/fiq_src_ctrl_tb.sv
module fiq_src_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam int DW = 32;

  localparam logic [AW-1:0] A_MODE = 3'd0;
  localparam logic [AW-1:0] A_SVEC = 3'd1;
  localparam logic [AW-1:0] A_FVEC = 3'd2;
  localparam logic [AW-1:0] A_EN   = 3'd3;
  localparam logic [AW-1:0] A_DIS  = 3'd4;
  localparam logic [AW-1:0] A_MASK = 3'd5;

  // {trigger[1:0], enable, input level, expected fiq_req_n}
  localparam int NVEC = 8;
  localparam logic [4:0] VECS [NVEC] = '{
    5'b00_1_1_0, 5'b00_1_0_1, 5'b00_0_1_1, 5'b10_1_0_0,
    5'b10_1_1_1, 5'b10_0_0_1, 5'b00_1_1_0, 5'b10_1_1_1
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fiq_in = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          fiq_req_n;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] rd_val;

  always #(CLK_PERIOD/2) clk = ~clk;

  fiq_src_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .fiq_in(fiq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fiq_req_n(fiq_req_n)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait_cyc(3);
    chk("R1 req during reset", fiq_req_n, 1);
    rst_n = 1'b1;
    wait_cyc(1);
    bus_read(A_MASK, rd_val); chk("R1 mask", rd_val, 0);
    bus_read(A_SVEC, rd_val); chk("R1 vector", rd_val, 0);
    bus_read(A_MODE, rd_val); chk("R1 mode", rd_val, 0);
    chk("R1 req after reset", fiq_req_n, 1);

    // table walk over the level modes
    for (int i = 0; i < NVEC; i++) begin
      bus_write(A_MODE, {30'd0, VECS[i][4:3]});
      bus_write(VECS[i][2] ? A_EN : A_DIS, 32'd1);
      fiq_in = VECS[i][1];
      wait_cyc(4);
      chk(VECS[i][4] ? "R3 low level" : "R2 high level", fiq_req_n, VECS[i][0]);
    end

    // R12: two-edge latency in high-level mode
    bus_write(A_MODE, 32'd0);
    bus_write(A_EN, 32'd1);
    fiq_in = 1'b0; wait_cyc(4);
    fiq_in = 1'b1;
    wait_cyc(1); chk("R12 after one edge", fiq_req_n, 1);
    wait_cyc(1); chk("R12 after two edges", fiq_req_n, 0);

    // R7: vector read in level mode leaves request
    bus_write(A_SVEC, 32'hCAFE_F00D);
    bus_read(A_FVEC, rd_val); chk("R6 vector value", rd_val, 32'hCAFE_F00D);
    wait_cyc(1); chk("R7 level not cleared", fiq_req_n, 0);

    // R10: priority stored and ignored
    bus_write(A_MODE, 32'h0000_0070);
    bus_read(A_MODE, rd_val); chk("R10 priority readback", rd_val, 32'h70);
    wait_cyc(2); chk("R10 no effect on request", fiq_req_n, 0);

    // R4: rising edge latched
    fiq_in = 1'b0;
    bus_write(A_MODE, 32'd1);
    wait_cyc(4); chk("R4 idle before edge", fiq_req_n, 1);
    fiq_in = 1'b1; wait_cyc(3); fiq_in = 1'b0; wait_cyc(4);
    chk("R4 edge held after pulse", fiq_req_n, 0);

    // R9: disable masks, latch kept
    bus_write(A_DIS, 32'd1);
    chk("R9 masked", fiq_req_n, 1);
    bus_write(A_EN, 32'd1);
    chk("R9 held edge returns", fiq_req_n, 0);

    // R6: vector read clears edge
    bus_read(A_FVEC, rd_val); chk("R6 vector value edge", rd_val, 32'hCAFE_F00D);
    chk("R6 edge cleared", fiq_req_n, 1);

    // R5: falling edge mode
    bus_write(A_MODE, 32'd3);
    fiq_in = 1'b1; wait_cyc(4);
    chk("R5 rise ignored", fiq_req_n, 1);
    fiq_in = 1'b0; wait_cyc(4);
    chk("R5 fall latched", fiq_req_n, 0);
    bus_read(A_FVEC, rd_val);
    chk("R6 falling cleared", fiq_req_n, 1);

    // R11: command registers read zero
    bus_read(A_EN, rd_val);  chk("R11 enable cmd reads 0", rd_val, 0);
    bus_read(A_DIS, rd_val); chk("R11 disable cmd reads 0", rd_val, 0);

    // R8: zero writes ignored
    bus_write(A_DIS, 32'hFFFF_FFFE);
    bus_read(A_MASK, rd_val); chk("R8 zero disable ignored", rd_val, 1);
    bus_write(A_DIS, 32'd1);
    bus_read(A_MASK, rd_val); chk("R8 disabled", rd_val, 0);
    bus_write(A_EN, 32'd0);
    bus_read(A_MASK, rd_val); chk("R8 zero enable ignored", rd_val, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule